// File: doc/BRIEF.md
# Bus-Master DMA Channel Status Register

This block holds the status byte that software polls to follow a disk-interface bus-master DMA transfer. There is one copy of the state for each channel. With the default parameters there are two channels: the primary channel at register offset 02h and the secondary channel at offset 0Ah. Software reaches both through a single-cycle register port. The write takes effect on the clock edge, and the read data is combinational on the offset.

The DMA engine and the drive are not modelled. They appear only as per-channel inputs:
- a strobe for each write to the command register's start bit, with the value written;
- a pulse when the last transfer of an end-of-table descriptor completes;
- a pulse on a target abort or master abort;
- the raw drive interrupt line.

Each channel holds the following state:
- A running flag, which is also exported to the engine as `dma_active`.
- A sticky error flag.
- An interrupt flag, latched only on a fresh rising edge of the synchronised drive interrupt line.
- Two capability bits that software owns.

Software reads bit 2 and bit 0 together to learn the outcome of a transfer:
- bit 2 = 0, bit 0 = 1: the transfer is still running.
- bit 2 = 1, bit 0 = 0: normal completion, with the descriptor table used up.
- bit 2 = 1, bit 0 = 1: the drive finished before the descriptor table ended. This is also a valid completion.

Top module: `bmdma_stat`

## Requirements
- R1: After reset, every channel reads 00h and `dma_active` is 0.
- R2: The channel with index c is decoded at offset 02h + 8·c, so the primary channel is at 02h and the secondary at 0Ah. Any other offset reads 00h, and writes to other offsets change no channel.
- R3: Bit 7 and bits 4:3 always read 0, whatever is written to them.
- R4: Bit 6 (drive 1 capable) and bit 5 (drive 0 capable) read back the last value written to them. They affect no other bit.
- R5: The drive interrupt line is active high and passes through two synchronising flops. Bit 2 sets on the third clock edge after the line rises. Writing 1 to bit 2 clears it, and writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.
- R6: If bit 2 is cleared while the line stays high, it remains 0 until the line falls and then rises again.
- R7: A bus-abort pulse sets bit 1. Writing 1 to bit 1 clears it, and writing 0 leaves it unchanged. If an abort and a clear fall in the same cycle, the abort wins.
- R8: Bit 0 is read-only to register writes. It sets on the edge after a command-start strobe carrying 1. Without a start or clear event, it holds its value.
- R9: Bit 0 clears on the edge after any of three events: an end-of-table completion, a command-start strobe carrying 0, or a bus abort. If a clear event and a start fall in the same cycle, the clear wins.
- R10: Channels keep fully independent state. Events and writes on one channel never change another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (4) | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cmd_wr | input | NCH (2) | Per-channel strobe: the command start bit was written |
| cmd_start | input | NCH (2) | Value written to the start bit, qualified by `cmd_wr` |
| eot_done | input | NCH (2) | Last transfer of an end-of-table descriptor completed |
| bus_abort | input | NCH (2) | Target abort or master abort seen on the bus |
| drv_irq | input | NCH (2) | Raw drive interrupt line, active high |
| dma_active | output | NCH (2) | Per-channel running flag (bit 0) |

## Verification
The bench clears the interrupt flag while the line is still high and checks that the flag stays 0 until a real new edge arrives. A design that set bit 2 on level rather than on edge would show the flag again one cycle later. It also counts the three-edge synchroniser latency exactly, so a missing or extra flop shows up as an early or late bit 2.

It fires set events in the same cycle as write-one-to-clear, and start strobes in the same cycle as end-of-table. A wrong priority would read back a cleared error or interrupt flag, or a channel left running. It also drives each of the three clear paths of bit 0, and checks writes to bits 0, 7 and 4:3 and writes to the other channel's offset. These would expose a writable status bit or a shared decode.

// File: rtl/bmdma_stat.sv
module bmdma_stat #(
  parameter int NCH      = 2,
  parameter int AW       = 4,
  parameter int BASE_OFS = 2,
  parameter int STRIDE   = 8,
  parameter int SYNC_N   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic [NCH-1:0] cmd_wr,
  input  logic [NCH-1:0] cmd_start,
  input  logic [NCH-1:0] eot_done,
  input  logic [NCH-1:0] bus_abort,
  input  logic [NCH-1:0] drv_irq,
  output logic [NCH-1:0] dma_active
);

  logic [NCH-1:0] act_q, err_q, irq_q;
  logic [7:0]     rd_word [NCH];

  assign dma_active = act_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] OFS = AW'(BASE_OFS + STRIDE * c);

    logic [SYNC_N:0] sync_q;
    logic [1:0]      cap_q;
    logic            hit, sel, rise, stop;

    assign hit  = (reg_addr == OFS);
    assign sel  = reg_wr && hit;
    assign rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
    assign stop = eot_done[c] | (cmd_wr[c] & ~cmd_start[c]) | bus_abort[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q   <= '0;
        cap_q    <= '0;
        act_q[c] <= 1'b0;
        err_q[c] <= 1'b0;
        irq_q[c] <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_N-1:0], drv_irq[c]};
        if (sel) cap_q <= reg_wdata[6:5];

        if (rise)                      irq_q[c] <= 1'b1;
        else if (sel && reg_wdata[2])  irq_q[c] <= 1'b0;

        if (bus_abort[c])              err_q[c] <= 1'b1;
        else if (sel && reg_wdata[1])  err_q[c] <= 1'b0;

        if (stop)                      act_q[c] <= 1'b0;
        else if (cmd_wr[c])            act_q[c] <= 1'b1;
      end
    end

    assign rd_word[c] = hit ? {1'b0, cap_q, 2'b00, irq_q[c], err_q[c], act_q[c]} : 8'h00;
  end

  always_comb begin
    reg_rdata = 8'h00;
    for (int c = 0; c < NCH; c++) reg_rdata |= rd_word[c];
  end

endmodule

module bmdma_stat_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [7:0]     reg_rdata,
  input logic [NCH-1:0] cmd_wr,
  input logic [NCH-1:0] cmd_start,
  input logic [NCH-1:0] eot_done,
  input logic [NCH-1:0] bus_abort,
  input logic [NCH-1:0] dma_active,
  input logic [NCH-1:0] err_q
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] == 1'b0) && (reg_rdata[4:3] == 2'b00)); // R3

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_ABORT_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      bus_abort[c] |=> err_q[c]); // R7
    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_abort[c] |=> !dma_active[c]); // R9
    AST_EOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      eot_done[c] |=> !dma_active[c]); // R9
    AST_CMD_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr[c] && !cmd_start[c]) |=> !dma_active[c]); // R9
    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr[c] && cmd_start[c] && !eot_done[c] && !bus_abort[c]) |=> dma_active[c]); // R8
    AST_ACT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_wr[c] && !eot_done[c] && !bus_abort[c]) |=> $stable(dma_active[c])); // R8
  end

endmodule

bind bmdma_stat bmdma_stat_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata),
  .cmd_wr(cmd_wr), .cmd_start(cmd_start), .eot_done(eot_done),
  .bus_abort(bus_abort), .dma_active(dma_active), .err_q(err_q)
);

// File: tb/bmdma_stat_tb.sv
module bmdma_stat_tb_top;
  localparam int NCH = 2;
  localparam int AW  = 4;
  localparam logic [AW-1:0] PRI = 4'h2;
  localparam logic [AW-1:0] SEC = 4'hA;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_wr = 1'b0;
  logic [AW-1:0]  reg_addr = '0;
  logic [7:0]     reg_wdata = '0;
  logic [7:0]     reg_rdata;
  logic [NCH-1:0] cmd_wr = '0, cmd_start = '0, eot_done = '0, bus_abort = '0, drv_irq = '0;
  logic [NCH-1:0] dma_active;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  bmdma_stat #(.NCH(NCH), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_wr(cmd_wr),
    .cmd_start(cmd_start), .eot_done(eot_done), .bus_abort(bus_abort),
    .drv_irq(drv_irq), .dma_active(dma_active)
  );

  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        failures++;
        $display("FAIL %s: rdata=%02h expected=%02h", t, reg_rdata, e);
      end
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic strobe(input int ch, input logic st, input logic sv, input logic eo, input logic ab);
    @(negedge clk);
    cmd_wr[ch] = st; cmd_start[ch] = sv; eot_done[ch] = eo; bus_abort[ch] = ab;
    @(negedge clk);
    cmd_wr[ch] = 1'b0; cmd_start[ch] = 1'b0; eot_done[ch] = 1'b0; bus_abort[ch] = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_act(input logic [NCH-1:0] e, input string t);
    @(negedge clk);
    #1;
    checks++;
    if (dma_active !== e) begin
      failures++;
      $display("FAIL %s: dma_active=%b expected=%b", t, dma_active, e);
    end
  endtask

  initial begin
    fork
      begin
        idle(3);
        rst_n = 1'b1;
        rd(PRI, 8'h00, "R1 primary reset");
        rd(SEC, 8'h00, "R1 secondary reset");
        check_act(2'b00, "R1 active reset");

        wr(PRI, 8'hFF);
        rd(PRI, 8'h60, "R3 R4 R8 write FF keeps only capability bits");
        rd(SEC, 8'h00, "R10 secondary untouched");
        rd(4'h3, 8'h00, "R2 unmapped offset reads zero");
        wr(4'h6, 8'h60);
        rd(SEC, 8'h00, "R2 write to unmapped offset ignored");

        strobe(0, 1'b1, 1'b1, 1'b0, 1'b0);
        rd(PRI, 8'h61, "R8 start sets active");
        check_act(2'b01, "R8 active output");

        @(negedge clk); drv_irq[0] = 1'b1;
        rd(PRI, 8'h61, "R5 one edge after rise");
        rd(PRI, 8'h61, "R5 two edges after rise");
        rd(PRI, 8'h65, "R5 irq set on third edge, running");

        strobe(0, 1'b0, 1'b0, 1'b1, 1'b0);
        rd(PRI, 8'h64, "R9 end-of-table clears active");

        wr(PRI, 8'h60);
        rd(PRI, 8'h64, "R5 writing 0 to bit 2 no effect");
        wr(PRI, 8'h64);
        rd(PRI, 8'h60, "R5 write-one clears bit 2");
        idle(5);
        rd(PRI, 8'h60, "R6 bit 2 stays clear while line high");
        @(negedge clk); drv_irq[0] = 1'b0;
        idle(4);
        @(negedge clk); drv_irq[0] = 1'b1;
        rd(PRI, 8'h60, "R6 new edge, sync stage 1");
        rd(PRI, 8'h60, "R6 new edge, sync stage 2");
        rd(PRI, 8'h64, "R6 new edge sets bit 2");
        wr(PRI, 8'h64);

        strobe(0, 1'b1, 1'b1, 1'b0, 1'b0);
        strobe(0, 1'b0, 1'b0, 1'b0, 1'b1);
        rd(PRI, 8'h62, "R7 R9 abort sets error, clears active");
        wr(PRI, 8'h60);
        rd(PRI, 8'h62, "R7 writing 0 to bit 1 no effect");
        wr(PRI, 8'h62);
        rd(PRI, 8'h60, "R7 write-one clears bit 1");

        @(negedge clk);
        bus_abort[0] = 1'b1; reg_wr = 1'b1; reg_addr = PRI; reg_wdata = 8'h62;
        @(negedge clk);
        bus_abort[0] = 1'b0; reg_wr = 1'b0;
        rd(PRI, 8'h62, "R7 abort wins over clear");

        strobe(1, 1'b1, 1'b1, 1'b0, 1'b0);
        rd(SEC, 8'h01, "R8 R10 secondary start");
        rd(PRI, 8'h62, "R10 primary unaffected");
        strobe(1, 1'b1, 1'b0, 1'b0, 1'b0);
        rd(SEC, 8'h00, "R9 start bit written 0 clears active");
        strobe(1, 1'b1, 1'b1, 1'b1, 1'b0);
        rd(SEC, 8'h00, "R9 end-of-table wins over start");
        strobe(1, 1'b1, 1'b1, 1'b0, 1'b1);
        rd(SEC, 8'h02, "R9 abort wins over start");
        wr(SEC, 8'h02);

        @(negedge clk); drv_irq[1] = 1'b1;
        idle(1);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = SEC; reg_wdata = 8'h04;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(SEC, 8'h04, "R5 irq set wins over clear");
        rd(PRI, 8'h62, "R10 primary unchanged by secondary irq");
        wr(SEC, 8'h21);
        rd(SEC, 8'h24, "R4 R8 capability written, bit 0 not writable");
        check_act(2'b00, "R4 capability has no effect on active");
        idle(2);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: expired expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule